// File: doc/BRIEF.md
# Serial Receiver Wake-up Controller

This block sits behind a UART-style receiver and decides what happens to each deserialized frame. Normally every completed frame is delivered: its payload goes into a receive data register and a data-full flag is raised. Software can instead put the receiver to sleep by setting the wake-up control bit. While asleep, frames do not normally raise the data-full flag. The receiver leaves the sleeping state only on a qualifying event, and that event depends on the selected wake-up method.

In address-mark mode, a frame whose address bit is set wakes the receiver. That frame is delivered and the receiver goes straight to the Run state. Frames without the address bit are dropped for flag purposes. In idle-line mode, an idle-character pulse wakes the receiver into the Ready state. In every state, error indications that come with a frame are still recorded in sticky error flags. The interrupt request follows the data-full flag, gated by the interrupt enable.

Bit sampling and baud generation are handled elsewhere. Frames arrive as a one-cycle strobe that carries the payload, the address bit and the error bits.

Top module: `rxwake_top`

## Requirements
- R1: A frame strobe copies its payload into `rxData` on the next clock edge only if `dataFull` is 0 in that cycle. This applies in every state, including the wake-up state. When `dataFull` is 1, `rxData` holds its value.
- R2: In address-mark mode (`modeIdle`=0), a frame with `frameAddr`=1 arriving in the wake-up state sets `dataFull` on the next edge.
- R3: `rxIrq` is 1 exactly when `dataFull` and `rxIntEn` are both 1, so a waking address frame raises an interrupt when the enable is set.
- R4: In address-mark mode, a frame with `frameAddr`=1 arriving in the wake-up state moves the receiver to Run and clears `wakeBit`. The state encoding is Ready=2'b00, Run=2'b01, Wake=2'b10.
- R5: In idle-line mode (`modeIdle`=1), an `idleDet` pulse in the wake-up state moves the receiver to Ready and clears `wakeBit`. Frames in that mode, even with the address bit set, leave the wake-up state and `dataFull` unchanged. `idleDet` has no effect on the wake-up state in address-mark mode.
- R6: Each bit of `errIn` that is set together with a frame strobe sets the matching sticky bit of `errFlags`, in any state. An `errClr` pulse clears all bits, and it wins over a set in the same cycle.
- R7: In address-mark mode, a frame with `frameAddr`=0 arriving in the wake-up state leaves `dataFull` unchanged, and the receiver stays asleep.
- R8: A `fullClr` pulse clears `dataFull` on the next edge, and it takes priority over a set in the same cycle.
- R9: A `wakeSet` pulse in Ready or Run puts the receiver into the wake-up state with `wakeBit`=1. A `wakeSet` pulse in the wake-up state changes nothing.
- R10: Outside the wake-up state, every frame sets `dataFull` and leaves the receiver in Run. An `idleDet` pulse in Run moves the receiver to Ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | One-cycle strobe: a frame has completed |
| frameData | input | DATA_W | Payload of the completed frame |
| frameAddr | input | 1 | Address bit of the completed frame |
| errIn | input | ERR_W | Error indications valid with frameValid |
| idleDet | input | 1 | One-cycle idle-character detect pulse |
| modeIdle | input | 1 | Wake method: 0 address-mark, 1 idle-line |
| wakeSet | input | 1 | Software write of 1 to the wake-up control bit |
| rxIntEn | input | 1 | Receive interrupt enable |
| fullClr | input | 1 | One-cycle clear of the data-full flag |
| errClr | input | 1 | One-cycle clear of the error flags |
| rxData | output | DATA_W | Receive data register |
| dataFull | output | 1 | Data-full flag |
| rxIrq | output | 1 | Receive interrupt request |
| rxState | output | 2 | Receiver state (00 Ready, 01 Run, 10 Wake) |
| wakeBit | output | 1 | Current value of the wake-up control bit |
| errFlags | output | ERR_W | Sticky error flags |

## Verification
The assertions check the following on every cycle:
- Both wake exits and the state each one reaches.
- That an address-clear frame cannot disturb a sleeping receiver.
- That the data register is frozen while the flag is full.
- The priority of the clear pulses.
- The stickiness of error bits.
- The interrupt equation.

Some behaviours only the bench scenarios can show. These are the exact payload that ends up in the register, both for frames copied while asleep and for frames blocked by a full flag. They also include the idle-line mode ignoring address frames, and a chain of sleep and wake cycles run through both methods.

// File: rtl/rxwake_pkg.sv
package rxwake_pkg;
  typedef enum logic [1:0] {
    ST_READY = 2'b00,
    ST_RUN   = 2'b01,
    ST_WAKE  = 2'b10
  } rxState_e;

  typedef struct packed {
    logic loadData;
    logic setFull;
  } dpStrobe_t;
endpackage

// File: rtl/rxwake_ctrl.sv
module rxwake_ctrl
  import rxwake_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameValid,
  input  logic      frameAddr,
  input  logic      idleDet,
  input  logic      modeIdle,
  input  logic      wakeSet,
  input  logic      fullNow,
  output dpStrobe_t strb,
  output rxState_e  state
);
  rxState_e stateNext;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      ST_READY, ST_RUN: begin
        if (frameValid) begin
          // awake: every frame is delivered
          strb.loadData = !fullNow;
          strb.setFull  = 1'b1;
          stateNext     = ST_RUN;
        end else if (idleDet && state == ST_RUN) begin
          stateNext = ST_READY;
        end
      end
      ST_WAKE: begin
        if (frameValid) begin
          // payload is still captured while asleep when the register is free
          strb.loadData = !fullNow;
          if (!modeIdle && frameAddr) begin
            strb.setFull = 1'b1;
            stateNext    = ST_RUN;
          end
        end
        if (modeIdle && idleDet) begin
          stateNext = ST_READY;
        end
      end
      default: stateNext = ST_READY;
    endcase
    if (wakeSet && state != ST_WAKE) begin
      stateNext = ST_WAKE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_READY;
    else       state <= stateNext;
  end
endmodule

// File: rtl/rxwake_dp.sv
module rxwake_dp
  import rxwake_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameValid,
  input  logic [ERR_W-1:0]  errIn,
  input  logic              fullClr,
  input  logic              errClr,
  input  logic              rxIntEn,
  output logic [DATA_W-1:0] rxData,
  output logic              dataFull,
  output logic              rxIrq,
  output logic [ERR_W-1:0]  errFlags
);
  always_ff @(posedge clk) begin
    if (!rstN)              rxData <= '0;
    else if (strb.loadData) rxData <= frameData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             dataFull <= 1'b0;
    else if (fullClr)      dataFull <= 1'b0;
    else if (strb.setFull) dataFull <= 1'b1;
  end

  for (genvar i = 0; i < ERR_W; i++) begin : gErr
    always_ff @(posedge clk) begin
      if (!rstN)                        errFlags[i] <= 1'b0;
      else if (errClr)                  errFlags[i] <= 1'b0;
      else if (frameValid && errIn[i])  errFlags[i] <= 1'b1;
    end
  end

  assign rxIrq = dataFull & rxIntEn;
endmodule

// File: rtl/rxwake_top.sv
module rxwake_top
  import rxwake_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [DATA_W-1:0] frameData,
  input  logic              frameAddr,
  input  logic [ERR_W-1:0]  errIn,
  input  logic              idleDet,
  input  logic              modeIdle,
  input  logic              wakeSet,
  input  logic              rxIntEn,
  input  logic              fullClr,
  input  logic              errClr,
  output logic [DATA_W-1:0] rxData,
  output logic              dataFull,
  output logic              rxIrq,
  output logic [1:0]        rxState,
  output logic              wakeBit,
  output logic [ERR_W-1:0]  errFlags
);
  dpStrobe_t strb;
  rxState_e  state;

  rxwake_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .frameValid (frameValid),
    .frameAddr  (frameAddr),
    .idleDet    (idleDet),
    .modeIdle   (modeIdle),
    .wakeSet    (wakeSet),
    .fullNow    (dataFull),
    .strb       (strb),
    .state      (state)
  );

  rxwake_dp #(.DATA_W(DATA_W), .ERR_W(ERR_W)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .frameData  (frameData),
    .frameValid (frameValid),
    .errIn      (errIn),
    .fullClr    (fullClr),
    .errClr     (errClr),
    .rxIntEn    (rxIntEn),
    .rxData     (rxData),
    .dataFull   (dataFull),
    .rxIrq      (rxIrq),
    .errFlags   (errFlags)
  );

  assign rxState = state;
  assign wakeBit = (state == ST_WAKE);
endmodule

// File: rtl/rxwake_chk.sv
module rxwake_chk #(
  parameter int DATA_W = 8,
  parameter int ERR_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameValid,
  input logic              frameAddr,
  input logic [ERR_W-1:0]  errIn,
  input logic              idleDet,
  input logic              modeIdle,
  input logic              wakeSet,
  input logic              rxIntEn,
  input logic              fullClr,
  input logic              errClr,
  input logic [DATA_W-1:0] rxData,
  input logic              dataFull,
  input logic              rxIrq,
  input logic [1:0]        rxState,
  input logic              wakeBit,
  input logic [ERR_W-1:0]  errFlags
);
  localparam logic [1:0] S_READY = 2'b00;
  localparam logic [1:0] S_RUN   = 2'b01;
  localparam logic [1:0] S_WAKE  = 2'b10;

  AST_DATA_FROZEN_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    dataFull |=> $stable(rxData)); // R1

  AST_ADDR_SETS_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == S_WAKE && !modeIdle && frameValid && frameAddr && !fullClr) |=> dataFull); // R2

  AST_IRQ_FOLLOWS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq == (dataFull && rxIntEn)); // R3

  AST_ADDR_WAKE_TO_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == S_WAKE && !modeIdle && frameValid && frameAddr) |=> (rxState == S_RUN && !wakeBit)); // R4

  AST_IDLE_WAKE_TO_READY: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == S_WAKE && modeIdle && idleDet) |=> (rxState == S_READY && !wakeBit)); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && (|errIn) && !errClr) |=> ((errFlags & $past(errIn)) == $past(errIn))); // R6

  AST_ADDR_CLEAR_DISCARD: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == S_WAKE && !modeIdle && frameValid && !frameAddr && !fullClr)
      |=> ($stable(dataFull) && rxState == S_WAKE)); // R7

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    fullClr |=> !dataFull); // R8

  AST_ERRCLR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    errClr |=> (errFlags == '0)); // R6

  AST_ENTER_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (wakeSet && rxState != S_WAKE) |=> (rxState == S_WAKE && wakeBit)); // R9

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    rxState != 2'b11); // R10
endmodule

bind rxwake_top rxwake_chk #(.DATA_W(DATA_W), .ERR_W(ERR_W)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .frameValid (frameValid),
  .frameAddr  (frameAddr),
  .errIn      (errIn),
  .idleDet    (idleDet),
  .modeIdle   (modeIdle),
  .wakeSet    (wakeSet),
  .rxIntEn    (rxIntEn),
  .fullClr    (fullClr),
  .errClr     (errClr),
  .rxData     (rxData),
  .dataFull   (dataFull),
  .rxIrq      (rxIrq),
  .rxState    (rxState),
  .wakeBit    (wakeBit),
  .errFlags   (errFlags)
);

// File: tb/rxwake_tb.sv
`timescale 1ns/1ps
module rxwake_top_tb_top;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameValid = 1'b0;
  logic [DATA_W-1:0] frameData = '0;
  logic frameAddr = 1'b0;
  logic [ERR_W-1:0] errIn = '0;
  logic idleDet = 1'b0, modeIdle = 1'b0, wakeSet = 1'b0, rxIntEn = 1'b0;
  logic fullClr = 1'b0, errClr = 1'b0;
  logic [DATA_W-1:0] rxData;
  logic dataFull, rxIrq, wakeBit;
  logic [1:0] rxState;
  logic [ERR_W-1:0] errFlags;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rxwake_top #(.DATA_W(DATA_W), .ERR_W(ERR_W)) dut_i (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .frameAddr(frameAddr), .errIn(errIn), .idleDet(idleDet), .modeIdle(modeIdle),
    .wakeSet(wakeSet), .rxIntEn(rxIntEn), .fullClr(fullClr), .errClr(errClr),
    .rxData(rxData), .dataFull(dataFull), .rxIrq(rxIrq), .rxState(rxState),
    .wakeBit(wakeBit), .errFlags(errFlags)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock with the current inputs, then all strobes drop; outputs valid at the negedge
  task automatic cycle();
    @(negedge clk);
    frameValid = 1'b0; idleDet = 1'b0; wakeSet = 1'b0;
    fullClr = 1'b0; errClr = 1'b0; errIn = '0; frameAddr = 1'b0;
  endtask

  task automatic sendFrame(input logic [DATA_W-1:0] d, input logic a, input logic [ERR_W-1:0] e);
    frameValid = 1'b1; frameData = d; frameAddr = a; errIn = e;
    cycle();
  endtask

  task automatic testReset();
    check("R9 reset state", rxState, 0);
    check("R9 reset wakeBit", wakeBit, 0);
    check("R1 reset data", rxData, 0);
    check("R8 reset full", dataFull, 0);
    check("R6 reset errors", errFlags, 0);
  endtask

  task automatic testNormal();
    rxIntEn = 1'b1;
    sendFrame(8'h5A, 1'b0, '0);
    check("R10 frame sets full", dataFull, 1);
    check("R10 ready to run", rxState, 1);
    check("R1 data loaded", rxData, 8'h5A);
    check("R3 irq with enable", rxIrq, 1);
    sendFrame(8'h33, 1'b0, '0);
    check("R1 data held while full", rxData, 8'h5A);
    rxIntEn = 1'b0; #1;
    check("R3 irq gated by enable", rxIrq, 0);
    fullClr = 1'b1; cycle();
    check("R8 clear pulse", dataFull, 0);
    idleDet = 1'b1; cycle();
    check("R10 idle run to ready", rxState, 0);
  endtask

  task automatic testAddrWake();
    modeIdle = 1'b0; rxIntEn = 1'b1;
    wakeSet = 1'b1; cycle();
    check("R9 enter wake", rxState, 2);
    check("R9 wakeBit set", wakeBit, 1);
    sendFrame(8'h11, 1'b0, '0);
    check("R7 full unchanged", dataFull, 0);
    check("R7 stays asleep", rxState, 2);
    check("R1 copy while asleep", rxData, 8'h11);
    check("R7 no irq", rxIrq, 0);
    idleDet = 1'b1; cycle();
    check("R5 idle ignored in address mode", rxState, 2);
    wakeSet = 1'b1; cycle();
    check("R9 wakeSet in wake ignored", rxState, 2);
    sendFrame(8'h82, 1'b1, '0);
    check("R2 address frame sets full", dataFull, 1);
    check("R4 to run", rxState, 1);
    check("R4 wakeBit cleared", wakeBit, 0);
    check("R1 address payload", rxData, 8'h82);
    check("R3 wake irq", rxIrq, 1);
    // sleep again with the flag still full
    wakeSet = 1'b1; cycle();
    check("R9 enter wake from run", rxState, 2);
    sendFrame(8'h44, 1'b1, '0);
    check("R1 full blocks copy", rxData, 8'h82);
    check("R4 exit with full", rxState, 1);
    rxIntEn = 1'b0;
  endtask

  task automatic testIdleWake();
    fullClr = 1'b1; cycle();
    modeIdle = 1'b1;
    wakeSet = 1'b1; cycle();
    check("R9 enter wake idle mode", rxState, 2);
    sendFrame(8'h66, 1'b1, '0);
    check("R5 address frame no wake", rxState, 2);
    check("R5 address frame no full", dataFull, 0);
    check("R1 copy in idle mode", rxData, 8'h66);
    idleDet = 1'b1; cycle();
    check("R5 idle to ready", rxState, 0);
    check("R5 wakeBit cleared", wakeBit, 0);
    modeIdle = 1'b0;
  endtask

  task automatic testErrors();
    wakeSet = 1'b1; cycle();
    sendFrame(8'h01, 1'b0, 3'b101);
    check("R6 errors set while asleep", errFlags, 3'b101);
    check("R7 error frame stays asleep", rxState, 2);
    sendFrame(8'h02, 1'b0, 3'b010);
    check("R6 errors sticky", errFlags, 3'b111);
    errClr = 1'b1; cycle();
    check("R6 clear", errFlags, 0);
    errClr = 1'b1; sendFrame(8'h03, 1'b0, 3'b011);
    check("R6 clear wins", errFlags, 0);
  endtask

  task automatic testClrPriority();
    // receiver asleep in address mode, flag empty
    fullClr = 1'b1; sendFrame(8'h9C, 1'b1, '0);
    check("R8 clear beats set", dataFull, 0);
    check("R4 still wakes", rxState, 1);
    check("R1 payload on clear cycle", rxData, 8'h9C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testNormal();
    testAddrWake();
    testIdleWake();
    testErrors();
    testClrPriority();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule